// File: doc/BRIEF.md
# NAND Chunk Hamming Code Generator

This block sits beside the data port of a NAND flash controller and watches the bytes that pass through it. Over a chunk of 256 bytes it builds a 22-bit Hamming-style check value: sixteen line-parity bits derived from each byte's position within the chunk, and six column-parity bits derived from the bit positions within the bytes. The value is presented as three code bytes. Host software compares a stored code with a freshly computed one, and the difference locates and flips a single bad bit. The generator does no correction itself.

Software drives the generator through a small control register. One bit enables accumulation, one bit restarts it and one bit selects whether the code is presented inverted. In inverted mode a fully erased chunk, all 0xFF, produces an all-ones code, which matches the contents of an erased spare area. The code can be read one byte at a time. It can also be read as a 32-bit word at the status location, where the controller's status byte fills the low lane. After 256 bytes the accumulator stops and keeps its code until the next restart.

Top module: `nand_hecc_gen`

## Requirements
- R1: Once reset has been applied, the code bytes read LSB=0x00, MSB=0x00 and column=0x03, and the control register reads 0x00.
- R2: A write to offset 0x815 stores bit0 as accumulate-enable and bit2 as invert-mode. A read of 0x815 returns those two bits in positions 0 and 2 and all other bits as 0. Bit1 of the written value always reads back as 0.
- R3: A write to offset 0x815 with bit1 set zeroes every parity accumulator and the byte counter in that cycle.
- R4: For each bit k (0..7) of the byte index within the chunk, the "even" line bit is the XOR of the byte parities of all bytes whose index has bit k equal to 0, and the "odd" line bit covers the bytes whose index has bit k equal to 1. The even bit of index bit k sits at code bit 2k and the odd bit at 2k+1. Code bits 7:0 form the LSB byte and code bits 15:8 form the MSB byte.
- R5: The column byte holds six column parities, all taken over the whole chunk. Bit2 covers data bits {0,2,4,6}, bit3 covers {1,3,5,7}, bit4 covers {0,1,4,5}, bit5 covers {2,3,6,7}, bit6 covers {0..3} and bit7 covers {4..7}. Column bits 1:0 always read 1.
- R6: With invert-mode set, all 22 parity bits are presented complemented, so a chunk of 256 bytes of 0xFF yields the code 0xFF/0xFF/0xFF. With invert-mode clear, the parities are presented as computed.
- R7: A data byte is accumulated only in a cycle where both the data-valid strobe and accumulate-enable are high. Bytes offered while accumulation is disabled leave the code unchanged.
- R8: After 256 bytes have been accumulated, further data bytes are ignored until the next clear.
- R9: The word output carries the status byte in bits 7:0, the LSB code byte in bits 15:8, the MSB code byte in bits 23:16 and the column byte in bits 31:24.
- R10: If a clear write and a data byte arrive in the same cycle, that byte is dropped. The first byte accepted afterwards becomes index 0 of the new chunk.
- R11: Byte reads at 0x811, 0x812 and 0x813 return the LSB, MSB and column code bytes, and a byte read at 0x810 returns the status byte. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_vld | input | 1 | A byte is crossing the data port this cycle |
| dat_byte | input | 8 | Byte on the data port |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register offset for writes and reads |
| bus_wdata | input | 8 | Register write data |
| status_in | input | 8 | Controller status byte, merged into reads |
| rd_byte | output | 8 | Byte read result for bus_addr |
| rd_word | output | 32 | Word read result at the status location |

## Verification
The verification centres on two collisions. The first is a clear write arriving in the same cycle as a data byte. The bench drives the 0x07 control write and a data byte on one clock edge, then sends a known sequence. The result must match a software reference computed over the following bytes only, with the colliding byte left out. The second is a data byte arriving on the cycle after the 256th byte has been taken. Extra bytes are sent straight after a full chunk, and the code must still match the reference over exactly 256 bytes.

// File: rtl/nand_hecc_pkg.sv
// Shared definitions for the chunk Hamming code generator.
// Assumes 8-bit data bytes; the column-parity groups are fixed by that width.
package nand_hecc_pkg;

    // Stored control state.
    typedef struct packed {
        logic inv;   // present parity bits complemented
        logic en;    // accumulate data bytes
    } hecc_mode_t;

    // Column-parity contribution of one byte, bit j = parity of group j.
    function automatic logic [5:0] col_contrib(input logic [7:0] b);
        logic [5:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = ^b[3:0];
        c[5] = ^b[7:4];
        return c;
    endfunction

endpackage

// File: rtl/hecc_ctl.sv
// Control register of the code generator.
// Decodes writes to the control offset and keeps the enable and invert bits.
// Bit1 of a write produces a one-cycle clear pulse and is not stored.
// Assumes single-cycle write strobes.
module hecc_ctl
    import nand_hecc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CTL_OFS = 'h815
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output hecc_mode_t        mode,
    output logic              clr
);

    logic       hit;
    hecc_mode_t mode_q;

    // Write decode for the control offset.
    assign hit = bus_wr && (bus_addr == ADDR_W'(CTL_OFS));
    assign clr = hit && bus_wdata[1];
    assign mode = mode_q;

    // Control bits storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (hit) begin
            mode_q.en  <= bus_wdata[0];
            mode_q.inv <= bus_wdata[2];
        end
    end

    // R2: a control write lands in both stored bits on the next cycle.
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (mode_q.en == $past(bus_wdata[0]) && mode_q.inv == $past(bus_wdata[2])));

endmodule

// File: rtl/hecc_accum.sv
// Parity accumulator for one chunk.
// Counts accepted bytes and folds each byte's parity into the line-parity
// pair selected by every bit of its index. Also folds the column groups.
// Stops once CHUNK_BYTES bytes are in. A clear has priority over a byte.
module hecc_accum
    import nand_hecc_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 256,
    localparam int unsigned IDX_W = $clog2(CHUNK_BYTES),
    localparam int unsigned CNT_W = $clog2(CHUNK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_vld,
    input  logic [7:0]       dat_byte,
    input  logic             en,
    input  logic             clr,
    output logic [IDX_W-1:0] lp_even,
    output logic [IDX_W-1:0] lp_odd,
    output logic [5:0]       cp
);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] lp_even_q, lp_odd_q;
    logic [5:0]       cp_q;
    logic             full, take, bpar;

    // Acceptance of the current byte.
    assign full = (cnt_q == CNT_W'(CHUNK_BYTES));
    assign take = dat_vld && en && !full && !clr;
    assign idx  = cnt_q[IDX_W-1:0];
    assign bpar = ^dat_byte;

    // Byte counter within the chunk.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (take)     cnt_q <= cnt_q + 1'b1;
    end

    // Column-parity fold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cp_q <= '0;
        else if (take)     cp_q <= cp_q ^ col_contrib(dat_byte);
    end

    // One line-parity pair for each index bit.
    for (genvar g = 0; g < IDX_W; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lp_even_q[g] <= 1'b0;
                lp_odd_q[g]  <= 1'b0;
            end else if (take) begin
                if (idx[g]) lp_odd_q[g]  <= lp_odd_q[g]  ^ bpar;
                else        lp_even_q[g] <= lp_even_q[g] ^ bpar;
            end
        end
    end

    assign lp_even = lp_even_q;
    assign lp_odd  = lp_odd_q;
    assign cp      = cp_q;

    // R8: the count never exceeds the chunk length.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CHUNK_BYTES));
    // R3: a clear empties the accumulator.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && lp_even_q == '0 && lp_odd_q == '0 && cp_q == '0));
    // R7: with no data strobe the state holds.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_vld && !clr) |=> $stable({cnt_q, lp_even_q, lp_odd_q, cp_q}));
    // R8: a full chunk holds against further bytes.
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable({cnt_q, lp_even_q, lp_odd_q, cp_q}));
    // R10: a byte colliding with a clear is not counted.
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && dat_vld && en) |=> (cnt_q == '0));

endmodule

// File: rtl/hecc_readout.sv
// Read path of the code generator.
// Interleaves the line-parity pairs into the 16-bit line code, adds the
// column byte with its two fixed ones, applies optional inversion, and
// decodes byte reads. Purely combinational. Assumes 8 index bits.
module hecc_readout
    import nand_hecc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned STS_OFS = 'h810,
    parameter int unsigned LSB_OFS = 'h811,
    parameter int unsigned MSB_OFS = 'h812,
    parameter int unsigned COL_OFS = 'h813,
    parameter int unsigned CTL_OFS = 'h815,
    localparam int unsigned LINE_W = 2 * IDX_W
) (
    input  logic [IDX_W-1:0]  lp_even,
    input  logic [IDX_W-1:0]  lp_odd,
    input  logic [5:0]        cp,
    input  hecc_mode_t        mode,
    input  logic [7:0]        status_in,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        rd_byte,
    output logic [31:0]       rd_word
);

    logic [LINE_W-1:0] line;
    logic [7:0]        lsb_b, msb_b, col_b, ctl_b;

    // Interleave even/odd pairs: even at 2k, odd at 2k+1.
    for (genvar g = 0; g < IDX_W; g++) begin : g_pack
        assign line[2*g]     = lp_even[g];
        assign line[2*g + 1] = lp_odd[g];
    end

    // Code bytes with optional inversion.
    assign lsb_b = line[7:0]  ^ {8{mode.inv}};
    assign msb_b = line[15:8] ^ {8{mode.inv}};
    assign col_b = {cp ^ {6{mode.inv}}, 2'b11};
    assign ctl_b = {5'b0, mode.inv, 1'b0, mode.en};

    // Word view at the status location.
    assign rd_word = {col_b, msb_b, lsb_b, status_in};

    // Byte read decode.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(STS_OFS): rd_byte = status_in;
            ADDR_W'(LSB_OFS): rd_byte = lsb_b;
            ADDR_W'(MSB_OFS): rd_byte = msb_b;
            ADDR_W'(COL_OFS): rd_byte = col_b;
            ADDR_W'(CTL_OFS): rd_byte = ctl_b;
            default:          rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/nand_hecc_gen.sv
// Top of the chunk Hamming code generator.
// Snoops data-port bytes, accumulates a 22-bit code per chunk, and exposes
// it through byte reads and a status-overlaid word. Assumes at most one
// data byte per cycle and one register write per cycle.
module nand_hecc_gen
    import nand_hecc_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 256,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned STS_OFS     = 'h810,
    parameter int unsigned LSB_OFS     = 'h811,
    parameter int unsigned MSB_OFS     = 'h812,
    parameter int unsigned COL_OFS     = 'h813,
    parameter int unsigned CTL_OFS     = 'h815,
    localparam int unsigned IDX_W = $clog2(CHUNK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_vld,
    input  logic [7:0]        dat_byte,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        status_in,
    output logic [7:0]        rd_byte,
    output logic [31:0]       rd_word
);

    hecc_mode_t       mode;
    logic             clr;
    logic [IDX_W-1:0] lp_even, lp_odd;
    logic [5:0]       cp;

    // Control register.
    hecc_ctl #(.ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mode(mode), .clr(clr)
    );

    // Parity accumulation.
    hecc_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_acc (
        .clk(clk), .rst_n(rst_n), .dat_vld(dat_vld), .dat_byte(dat_byte),
        .en(mode.en), .clr(clr), .lp_even(lp_even), .lp_odd(lp_odd), .cp(cp)
    );

    // Read path.
    hecc_readout #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STS_OFS(STS_OFS), .LSB_OFS(LSB_OFS),
        .MSB_OFS(MSB_OFS), .COL_OFS(COL_OFS), .CTL_OFS(CTL_OFS)
    ) u_rd (
        .lp_even(lp_even), .lp_odd(lp_odd), .cp(cp), .mode(mode),
        .status_in(status_in), .bus_addr(bus_addr),
        .rd_byte(rd_byte), .rd_word(rd_word)
    );

endmodule

// File: tb/sim_nand_hecc_gen.sv
// Directed bench for the chunk Hamming code generator.
module sim_nand_hecc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_vld = 1'b0;
    logic [7:0]  dat_byte = 8'h00;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  status_in = 8'h00;
    logic [7:0]  rd_byte;
    logic [31:0] rd_word;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ref_buf [0:255];
    int ref_n = 0;

    always #10 clk = ~clk;

    nand_hecc_gen u0 (
        .clk(clk), .rst_n(rst_n), .dat_vld(dat_vld), .dat_byte(dat_byte),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .status_in(status_in), .rd_byte(rd_byte), .rd_word(rd_word)
    );

    // Software reference: returns {col, msb, lsb} over ref_buf[0:ref_n-1].
    function automatic logic [23:0] ref_code(input logic inv);
        logic [7:0] le = '0, lo = '0;
        logic [5:0] c = '0;
        logic [15:0] line;
        for (int i = 0; i < ref_n; i++) begin
            logic [7:0] b = ref_buf[i];
            logic p = ^b;
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) != 0) lo[k] = lo[k] ^ p;
                else                      le[k] = le[k] ^ p;
            end
            c[0] = c[0] ^ b[0] ^ b[2] ^ b[4] ^ b[6];
            c[1] = c[1] ^ b[1] ^ b[3] ^ b[5] ^ b[7];
            c[2] = c[2] ^ b[0] ^ b[1] ^ b[4] ^ b[5];
            c[3] = c[3] ^ b[2] ^ b[3] ^ b[6] ^ b[7];
            c[4] = c[4] ^ b[0] ^ b[1] ^ b[2] ^ b[3];
            c[5] = c[5] ^ b[4] ^ b[5] ^ b[6] ^ b[7];
        end
        for (int k = 0; k < 8; k++) begin
            line[2*k]   = le[k];
            line[2*k+1] = lo[k];
        end
        if (inv) begin
            line = ~line;
            c = ~c;
        end
        return {c, 2'b11, line[15:8], line[7:0]};
    endfunction

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'(((i * 37) + (seed * 11) + (i >> 2)) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = rd_byte;
    endtask

    task automatic check_code(input string tag, input logic [23:0] exp);
        logic [7:0] l, m, c;
        rd(12'h811, l);
        rd(12'h812, m);
        rd(12'h813, c);
        chk({c, m, l} == exp, tag, {8'h00, c, m, l}, {8'h00, exp});
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h815; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bool_rec);
        @(negedge clk);
        dat_vld = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_vld = 1'b0;
        if (bool_rec && ref_n < 256) begin
            ref_buf[ref_n] = b;
            ref_n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check_code("R1 reset code", 24'h030000);
        rd(12'h815, v);
        chk(v == 8'h00, "R1 reset ctl", {24'h0, v}, 32'h0);
    endtask

    task automatic t_ctl();
        logic [7:0] v;
        wr_ctl(8'hFF);
        rd(12'h815, v);
        chk(v == 8'h05, "R2 ctl readback all", {24'h0, v}, 32'h05);
        wr_ctl(8'h04);
        rd(12'h815, v);
        chk(v == 8'h04, "R2 ctl readback inv", {24'h0, v}, 32'h04);
        rd(12'h814, v);
        chk(v == 8'h00, "R11 unmapped", {24'h0, v}, 32'h0);
        status_in = 8'h3C;
        rd(12'h810, v);
        chk(v == 8'h3C, "R11 status byte", {24'h0, v}, 32'h3C);
    endtask

    task automatic t_erased();
        wr_ctl(8'h07);
        ref_n = 0;
        for (int i = 0; i < 256; i++) send(8'hFF, 1'b1);
        check_code("R6 erased chunk", 24'hFFFFFF);
    endtask

    task automatic t_pattern(input int seed, input logic inv);
        wr_ctl({5'b0, inv, 2'b11});
        ref_n = 0;
        for (int i = 0; i < 256; i++) send(pat(i, seed), 1'b1);
        check_code(inv ? "R4 R5 R6 pattern inv" : "R4 R5 pattern raw", ref_code(inv));
    endtask

    task automatic t_partial();
        wr_ctl(8'h03);
        ref_n = 0;
        for (int i = 0; i < 13; i++) send(pat(i, 7), 1'b1);
        check_code("R4 partial chunk", ref_code(1'b0));
        wr_ctl(8'h00);
        for (int i = 0; i < 5; i++) send(8'h81, 1'b0);
        check_code("R7 disabled bytes ignored", ref_code(1'b0));
        wr_ctl(8'h01);
        for (int i = 0; i < 4; i++) send(pat(i, 9), 1'b1);
        check_code("R7 resume without clear", ref_code(1'b0));
        wr_ctl(8'h06);
        check_code("R3 clear zeroes inverted", 24'hFFFFFF);
    endtask

    task automatic t_single_bit();
        logic [23:0] good, bad;
        wr_ctl(8'h07);
        ref_n = 0;
        for (int i = 0; i < 256; i++) send(pat(i, 3) ^ ((i == 147) ? 8'h20 : 8'h00), 1'b1);
        bad = ref_code(1'b1);
        check_code("R4 R5 single bit flip", bad);
        for (int i = 0; i < 256; i++) ref_buf[i] = pat(i, 3);
        good = ref_code(1'b1);
        chk((good ^ bad) != 24'h0, "R4 flip changes code", {8'h0, good ^ bad}, 32'h1);
    endtask

    task automatic t_full_stop();
        wr_ctl(8'h03);
        ref_n = 0;
        for (int i = 0; i < 256; i++) send(pat(i, 5), 1'b1);
        for (int i = 0; i < 6; i++) send(8'h17 + 8'(i), 1'b0);
        check_code("R8 bytes after full ignored", ref_code(1'b0));
    endtask

    task automatic t_collide();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h815; bus_wdata = 8'h07;
        dat_vld = 1'b1; dat_byte = 8'hA7;
        @(negedge clk);
        bus_wr = 1'b0; dat_vld = 1'b0;
        ref_n = 0;
        for (int i = 0; i < 9; i++) send(pat(i, 2), 1'b1);
        check_code("R10 colliding byte dropped", ref_code(1'b1));
    endtask

    task automatic t_word();
        logic [23:0] e;
        e = ref_code(1'b1);
        status_in = 8'h4C;
        #1;
        chk(rd_word == {e, 8'h4C}, "R9 word layout", rd_word, {e, 8'h4C});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_erased();
        t_pattern(1, 1'b0);
        t_pattern(4, 1'b1);
        t_partial();
        t_single_bit();
        t_full_stop();
        t_collide();
        t_word();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule